// File: doc/BRIEF.md
# Manchester Word Encoder with Type Sync

This block serializes one 16-bit word at a time onto a single-line biphase serial bus. Each word opens with a three-bit-time sync waveform that breaks Manchester rules. The polarity of the sync tells a receiver whether the word is a data word or a command/status word. Sixteen Manchester-coded payload bits follow, most significant bit first, and the word closes with one Manchester-coded odd parity bit.

A bus controller presents the payload and the word type, then pulses the start input. The block latches both and drives the line for 20 bit times with the line enable high and busy high. It then drops busy and pulses done for one clock. The clock runs at an integer multiple of the half-bit rate, and a parameter sets that multiple.

Top module: `mwt_encoder`

## Requirements
- R1: After reset, and whenever no word is in flight, line_en_o is 0, busy_o is 0, done_o is 0 and line_o sits at the IDLE_LVL parameter value (default 0).
- R2: With cmd_word_i = 0 (data word), the first six half-bit periods of the word are low, low, low, high, high, high.
- R3: With cmd_word_i = 1 (command/status word), the first six half-bit periods are high, high, high, low, low, low.
- R4: Payload bits follow the sync most significant bit first. Each bit takes two half-bit periods: a 1 is sent as high then low, and a 0 as low then high.
- R5: The last bit cell carries a parity bit, encoded as in R4, chosen so that the payload plus parity hold an odd number of ones.
- R6: Every half-bit period lasts exactly HALF_DIV clocks. busy_o and line_en_o stay high for exactly 40*HALF_DIV clocks, starting the clock after start_i is sampled.
- R7: start_i is sampled only while busy_o is 0. Changes on start_i, data_i and cmd_word_i during a word do not alter or restart it.
- R8: done_o is high for exactly one clock, in the first clock after busy_o falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, HALF_DIV times the half-bit rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, sampled while idle |
| cmd_word_i | input | 1 | 1 = command/status word, 0 = data word |
| data_i | input | 16 | Payload word |
| line_o | output | 1 | Serial line level |
| line_en_o | output | 1 | Line driver enable |
| busy_o | output | 1 | Word in flight |
| done_o | output | 1 | One-clock pulse at end of word |

## Verification
The bench builds the encoder with HALF_DIV = 3. This value gives each half-bit period several clocks, so a divider that is off by one, or a segment that is too short or too long, shows as a wrong line level at a known sampled clock. Because the sync segments are 9 clocks long, a sync that breaks Manchester rules is easy to tell from a legal bit sequence. Every clock of every word is compared against a waveform that the bench builds. The payloads are chosen so that the parity bit takes both values.

// File: rtl/mwt_pkg.sv
package mwt_pkg;
  parameter int unsigned WORD_W      = 16;
  parameter int unsigned SYNC_HALVES = 3;
  localparam int unsigned FRAME_HALVES = 2 * SYNC_HALVES + 2 * WORD_W + 2;
  localparam int unsigned HALF_CW      = $clog2(FRAME_HALVES);
  typedef logic [FRAME_HALVES-1:0] chips_t;
endpackage

// File: rtl/mwt_tick.sv
module mwt_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R6: with a divider above one, ticks never come back to back
  generate
    if (HALF_DIV > 1) begin : g_gap
      p_tick_gap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/mwt_frame.sv
module mwt_frame
  import mwt_pkg::*;
(
  input  logic [WORD_W-1:0] data_i,
  input  logic              cmd_word_i,
  output chips_t            chips_o
);
  localparam int unsigned PAY_TOP = FRAME_HALVES - 2 * SYNC_HALVES - 1;

  logic par;
  assign par = ~^data_i;

  // Sync: first half holds cmd_word_i, second half holds its inverse.
  genvar s;
  generate
    for (s = 0; s < SYNC_HALVES; s++) begin : g_sync
      assign chips_o[FRAME_HALVES-1-s]             = cmd_word_i;
      assign chips_o[FRAME_HALVES-1-SYNC_HALVES-s] = ~cmd_word_i;
    end
  endgenerate

  genvar b;
  generate
    for (b = 0; b < WORD_W; b++) begin : g_bit
      assign chips_o[PAY_TOP-2*b]   = data_i[WORD_W-1-b];
      assign chips_o[PAY_TOP-2*b-1] = ~data_i[WORD_W-1-b];
    end
  endgenerate

  assign chips_o[1] = par;
  assign chips_o[0] = ~par;
endmodule

// File: rtl/mwt_encoder.sv
module mwt_encoder
  import mwt_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter bit          IDLE_LVL = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cmd_word_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              line_o,
  output logic              line_en_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [HALF_CW-1:0] LAST_HALF = HALF_CW'(FRAME_HALVES - 1);

  chips_t             frame;
  chips_t             shreg_q;
  logic [HALF_CW-1:0] half_q;
  logic               busy_q, done_q, tick;

  mwt_frame i_frame (
    .data_i     (data_i),
    .cmd_word_i (cmd_word_i),
    .chips_o    (frame)
  );

  mwt_tick #(.HALF_DIV(HALF_DIV)) i_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      half_q  <= '0;
      shreg_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          shreg_q <= frame;
          half_q  <= '0;
        end
      end else if (tick) begin
        if (half_q == LAST_HALF) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          shreg_q <= shreg_q << 1;
          half_q  <= half_q + 1'b1;
        end
      end
    end
  end

  assign line_o    = busy_q ? shreg_q[FRAME_HALVES-1] : IDLE_LVL;
  assign line_en_o = busy_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_after_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $fell(busy_q));
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !(tick && half_q == LAST_HALF)) |=> (busy_q && half_q >= $past(half_q)));
  p_hold_half_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !tick) |=> $stable(shreg_q) && $stable(half_q));
  p_half_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    half_q <= LAST_HALF);
endmodule

// File: tb/test_mwt_encoder.sv
`timescale 1ns/1ps
module test_mwt_encoder;
  localparam int D  = 3;
  localparam int FH = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, cmd = 1'b0;
  logic [15:0] data = '0;
  logic line, line_en, busy, done;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  mwt_encoder #(.HALF_DIV(D), .IDLE_LVL(1'b0)) i_mwt_encoder (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_word_i(cmd),
    .data_i(data), .line_o(line), .line_en_o(line_en), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [FH-1:0] expect_wave(input logic [15:0] w, input logic c);
    logic [FH-1:0] v;
    int k = FH - 1;
    for (int i = 0; i < 3; i++) begin v[k] = c; k--; end
    for (int i = 0; i < 3; i++) begin v[k] = ~c; k--; end
    for (int i = 15; i >= 0; i--) begin
      v[k] = w[i]; v[k-1] = ~w[i]; k -= 2;
    end
    v[1] = ~^w; v[0] = ^w;
    return v;
  endfunction

  task automatic test_idle();
    @(negedge clk);
    chk("R1 line_en", line_en, 0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 line", line, 0);
  endtask

  task automatic test_word(input logic [15:0] w, input logic c, input bit disturb);
    logic [FH-1:0] ex = expect_wave(w, c);
    int e_sync = 0, e_pay = 0, e_par = 0, e_busy = 0;
    @(negedge clk);
    data = w; cmd = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 0; n < FH * D; n++) begin
      int h = n / D;
      if (n > 0) @(negedge clk);
      if (disturb && n == 30) begin data = ~w; cmd = ~c; start = 1'b1; end
      if (disturb && n == 31) start = 1'b0;
      if (line !== ex[FH-1-h]) begin
        if (h < 6) e_sync++; else if (h < 38) e_pay++; else e_par++;
      end
      if (busy !== 1'b1 || line_en !== 1'b1 || done !== 1'b0) e_busy++;
    end
    chk(c ? "R3 cmd sync" : "R2 data sync", e_sync, 0);
    chk(disturb ? "R7 payload under disturbance" : "R4 payload", e_pay, 0);
    chk("R5 parity", e_par, 0);
    chk("R6 busy width", e_busy, 0);
    @(negedge clk);
    chk("R6 busy falls", busy, 0);
    chk("R8 done high", done, 1);
    chk("R1 idle line", line, 0);
    @(negedge clk);
    chk("R8 done one clock", done, 0);
    chk("R1 line_en idle", line_en, 0);
  endtask

  task automatic test_busy_gap();
    // R7: no start while idle means the line stays idle
    int bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy || line_en || line) bad++;
    end
    chk("R7 no spontaneous start", bad, 0);
  endtask

  initial begin
    #20000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_idle();
    test_word(16'hA5C3, 1'b0, 1'b0);
    test_word(16'h0000, 1'b1, 1'b0);
    test_word(16'hFFFF, 1'b0, 1'b0);
    test_word(16'h0001, 1'b1, 1'b0);
    test_word(16'h8E17, 1'b0, 1'b1);
    test_busy_gap();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule